// File: doc/BRIEF.md
# Serial Receive Line Status Monitor

This block sits beside an asynchronous serial port and records three events in one status byte: a change of the receive line in a chosen direction, a disagreement between the level read back on the receive line and the bit being transmitted, and the arrival of a line break. Each event sets a sticky flag. The flag stays set until software clears it by writing a one to its bit. The line passes through its own synchronizer before any use. The bit-error check also stores the level it actually sampled, so software can tell which way the disagreement went.

The status byte is reached over a plain single-register bus with read and write strobes. The bus responds only while an alternate-map select input is high. One interrupt request combines each flag with its own enable input. Baud timing, framing, break-length qualification and the transmit shifter belong to neighbouring blocks: they provide the compare strobe, the transmitted bit and a break pulse.

Top module: `lsm_rx_monitor`

## Requirements
- R1: The status byte places the edge flag at bit 7, the sampled error level at bit 2, the bit-error flag at bit 1 and the break flag at bit 0. Bits 6 to 3 always read as 0.
- R2: The receive input passes through a two-stage synchronizer. The edge flag sets when the synchronized line falls while the polarity input is 0, or rises while it is 1. A change in the other direction does not set the flag.
- R3: A bus write with a 1 at a flag's bit position clears that flag. A 0 at that position leaves the flag unchanged.
- R4: The bit-error flag sets only in a cycle where detection is enabled, the compare strobe is high and the synchronized line differs from the transmitted bit.
- R5: On each such mismatch the error level bit takes the synchronized line level: 1 means high was seen where low was sent, and 0 means the reverse. It keeps its value at all other times, including when the flag is cleared.
- R6: The break flag sets only in a cycle where break detection is enabled and the break pulse input is high.
- R7: The interrupt output is high when any flag is set together with its own enable. It is registered, so it changes on the same edge as the flags, and an enable change shows one cycle later.
- R8: Reads and writes take effect only while the alternate-map select is 1. Otherwise a read returns 0 and a write leaves every flag unchanged.
- R9: After reset every status bit, the read data and the interrupt are 0.
- R10: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R11: Read data is registered. It shows the status byte as it stood at the clock edge that accepted the read, and it reads 0 after a cycle with no accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Receive line, asynchronous |
| rx_pol_i | input | 1 | Edge direction select: 0 falling, 1 rising |
| tx_bit_i | input | 1 | Bit currently being transmitted |
| cmp_stb_i | input | 1 | Strobe to compare the line against tx_bit_i |
| brk_rx_i | input | 1 | Break-received pulse from the receiver |
| berr_det_en_i | input | 1 | Enables bit-error detection |
| brk_det_en_i | input | 1 | Enables break detection |
| edge_ie_i | input | 1 | Interrupt enable for the edge flag |
| berr_ie_i | input | 1 | Interrupt enable for the bit-error flag |
| brk_ie_i | input | 1 | Interrupt enable for the break flag |
| alt_map_i | input | 1 | Alternate-map select; the register is reachable only when 1 |
| reg_rd_i | input | 1 | Read strobe |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data; ones clear the matching flags |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A flag's hardware set and a software write-1 clear can land on the same clock edge. The bench provokes this by raising the break pulse, with detection enabled, in the same cycle as a write of 0x01. It then clears the flag in a quiet cycle and checks that this second clear does take effect. A later read must show bit 0 still set after the collision and clear after the quiet write. A bound property also requires the break flag to be set on the cycle after any enabled break pulse, whatever the bus is doing.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 3;
  // index of each flag inside the internal flag vector
  localparam int FL_BRK  = 0;
  localparam int FL_BERR = 1;
  localparam int FL_EDGE = 2;
  // bit positions inside the status byte (software decodes these)
  localparam int BIT_BRK  = 0;
  localparam int BIT_BERR = 1;
  localparam int BIT_BVAL = 2;
  localparam int BIT_EDGE = 7;

  function automatic logic [REG_W-1:0] pack_status(
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 bval
  );
    logic [REG_W-1:0] r;
    r           = '0;
    r[BIT_BRK]  = flags[FL_BRK];
    r[BIT_BERR] = flags[FL_BERR];
    r[BIT_BVAL] = bval;
    r[BIT_EDGE] = flags[FL_EDGE];
    return r;
  endfunction
endpackage

// File: rtl/lsm_sync.sv
module lsm_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lsm_edge_det.sv
module lsm_edge_det #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  input  logic pol_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= d_i;
  end

  // pol_i = 1 selects rising, 0 selects falling
  assign edge_o = pol_i ? (d_i & ~prev_q) : (~d_i & prev_q);
endmodule

// File: rtl/lsm_flag_cell.sv
module lsm_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  logic q;

  // a set in the same cycle as a clear wins
  always_comb begin
    if (set_i)      nxt_o = 1'b1;
    else if (clr_i) nxt_o = 1'b0;
    else            nxt_o = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt_o;
  end

  assign q_o = q;
endmodule

// File: rtl/lsm_rx_monitor.sv
module lsm_rx_monitor
  import lsm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit RX_IDLE     = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             rx_pol_i,
  input  logic             tx_bit_i,
  input  logic             cmp_stb_i,
  input  logic             brk_rx_i,
  input  logic             berr_det_en_i,
  input  logic             brk_det_en_i,
  input  logic             edge_ie_i,
  input  logic             berr_ie_i,
  input  logic             brk_ie_i,
  input  logic             alt_map_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  logic                 rx_s;
  logic                 edge_hit;
  logic                 mismatch;
  logic                 brk_hit;
  logic                 wr_acc;
  logic                 rd_acc;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] ie_vec;
  logic [NUM_FLAGS-1:0] flag_nxt;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 berr_val_q;
  logic [REG_W-1:0]     rdata_q;
  logic                 irq_q;
  logic                 unused_wbits;

  lsm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RX_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d_i(rx_i), .q_o(rx_s)
  );

  lsm_edge_det #(.RST_VAL(RX_IDLE)) u_edge (
    .clk(clk), .rst(rst), .d_i(rx_s), .pol_i(rx_pol_i), .edge_o(edge_hit)
  );

  assign mismatch = cmp_stb_i & berr_det_en_i & (rx_s ^ tx_bit_i);
  assign brk_hit  = brk_rx_i & brk_det_en_i;
  assign wr_acc   = reg_wr_i & alt_map_i;
  assign rd_acc   = reg_rd_i & alt_map_i;

  always_comb begin
    set_vec          = '0;
    set_vec[FL_EDGE] = edge_hit;
    set_vec[FL_BERR] = mismatch;
    set_vec[FL_BRK]  = brk_hit;
    clr_vec          = '0;
    clr_vec[FL_EDGE] = wr_acc & reg_wdata_i[BIT_EDGE];
    clr_vec[FL_BERR] = wr_acc & reg_wdata_i[BIT_BERR];
    clr_vec[FL_BRK]  = wr_acc & reg_wdata_i[BIT_BRK];
    ie_vec           = '0;
    ie_vec[FL_EDGE]  = edge_ie_i;
    ie_vec[FL_BERR]  = berr_ie_i;
    ie_vec[FL_BRK]   = brk_ie_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    lsm_flag_cell u_cell (
      .clk(clk), .rst(rst), .set_i(set_vec[g]), .clr_i(clr_vec[g]),
      .nxt_o(flag_nxt[g]), .q_o(flag_q[g])
    );
  end

  // sampled level is kept until the next mismatch
  always_ff @(posedge clk) begin
    if (rst)           berr_val_q <= 1'b0;
    else if (mismatch) berr_val_q <= rx_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_acc ? pack_status(flag_q, berr_val_q) : '0;
      irq_q   <= |(flag_nxt & ie_vec);
    end
  end

  assign reg_rdata_o  = rdata_q;
  assign irq_o        = irq_q;
  assign unused_wbits = ^{reg_wdata_i[BIT_EDGE-1:BIT_BVAL]};
endmodule

// File: rtl/lsm_rx_monitor_chk.sv
module lsm_rx_monitor_chk
  import lsm_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 brk_rx_i,
  input logic                 brk_det_en_i,
  input logic                 berr_det_en_i,
  input logic                 cmp_stb_i,
  input logic                 edge_ie_i,
  input logic                 berr_ie_i,
  input logic                 brk_ie_i,
  input logic                 alt_map_i,
  input logic                 reg_rd_i,
  input logic                 reg_wr_i,
  input logic [REG_W-1:0]     reg_wdata_i,
  input logic [REG_W-1:0]     reg_rdata_o,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] flag_q,
  input logic                 berr_val_q
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rdata_o[BIT_EDGE-1:BIT_BVAL+1] == '0);

  a_r8_no_read_off_map: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_i && !alt_map_i) |=> reg_rdata_o == '0);

  a_r6_break_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[FL_BRK]) |-> $past(brk_rx_i && brk_det_en_i));

  a_r4_berr_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[FL_BERR]) |-> $past(cmp_stb_i && berr_det_en_i));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (brk_rx_i && brk_det_en_i) |=> flag_q[FL_BRK]);

  a_r3_clear_brk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_i && alt_map_i && reg_wdata_i[BIT_BRK] && !(brk_rx_i && brk_det_en_i))
      |=> !flag_q[FL_BRK]);

  a_r5_value_holds: assert property (@(posedge clk) disable iff (rst)
    !(cmp_stb_i && berr_det_en_i) |=> $stable(berr_val_q));

  a_r7_irq_combine: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_o == ((flag_q[FL_EDGE] && $past(edge_ie_i)) ||
                       (flag_q[FL_BERR] && $past(berr_ie_i)) ||
                       (flag_q[FL_BRK]  && $past(brk_ie_i))));
endmodule

bind lsm_rx_monitor lsm_rx_monitor_chk u_chk (
  .clk(clk), .rst(rst), .brk_rx_i(brk_rx_i), .brk_det_en_i(brk_det_en_i),
  .berr_det_en_i(berr_det_en_i), .cmp_stb_i(cmp_stb_i), .edge_ie_i(edge_ie_i),
  .berr_ie_i(berr_ie_i), .brk_ie_i(brk_ie_i), .alt_map_i(alt_map_i),
  .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .flag_q(flag_q),
  .berr_val_q(berr_val_q)
);

// File: tb/tb_lsm_rx_monitor.sv
`timescale 1ns/1ps
module tb_lsm_rx_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_i = 1'b1, rx_pol_i = 1'b0, tx_bit_i = 1'b1, cmp_stb_i = 1'b0;
  logic       brk_rx_i = 1'b0, berr_det_en_i = 1'b0, brk_det_en_i = 1'b0;
  logic       edge_ie_i = 1'b0, berr_ie_i = 1'b0, brk_ie_i = 1'b0;
  logic       alt_map_i = 1'b1, reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_o;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lsm_rx_monitor dut (
    .clk(clk), .rst(rst), .rx_i(rx_i), .rx_pol_i(rx_pol_i), .tx_bit_i(tx_bit_i),
    .cmp_stb_i(cmp_stb_i), .brk_rx_i(brk_rx_i), .berr_det_en_i(berr_det_en_i),
    .brk_det_en_i(brk_det_en_i), .edge_ie_i(edge_ie_i), .berr_ie_i(berr_ie_i),
    .brk_ie_i(brk_ie_i), .alt_map_i(alt_map_i), .reg_rd_i(reg_rd_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); reg_rd_i = 1'b1;
    @(negedge clk); reg_rd_i = 1'b0; v = reg_rdata_o;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R9 rdata after reset", reg_rdata_o, 8'h00);
    check("R9 irq after reset", {7'd0, irq_o}, 8'h00);
    rd(v); check("R9 status after reset", v, 8'h00);
    @(negedge clk); check("R11 rdata idle", reg_rdata_o, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] v;
    rx_pol_i = 1'b0; rx_i = 1'b0; idle(4);
    rd(v); check("R2 falling edge pol0", v, 8'h80);
    wr(8'h80); rd(v); check("R3 clear edge flag", v, 8'h00);
    rx_pol_i = 1'b1; idle(2); rx_i = 1'b1; idle(4);
    rd(v); check("R2 rising edge pol1", v, 8'h80);
    wr(8'h80); rx_i = 1'b0; idle(4);
    rd(v); check("R2 falling ignored pol1", v, 8'h00);
    rx_pol_i = 1'b0; idle(2); rx_i = 1'b1; idle(4);
    rd(v); check("R2 rising ignored pol0", v, 8'h00);
  endtask

  task automatic t_berr;
    logic [7:0] v;
    // line is high here; transmitted 0 makes a mismatch
    berr_det_en_i = 1'b0; tx_bit_i = 1'b0;
    @(negedge clk); cmp_stb_i = 1'b1; @(negedge clk); cmp_stb_i = 1'b0;
    rd(v); check("R4 no berr while disabled", v, 8'h00);
    berr_det_en_i = 1'b1;
    @(negedge clk); cmp_stb_i = 1'b1; @(negedge clk); cmp_stb_i = 1'b0;
    rd(v); check("R5 R1 berr high seen", v, 8'h06);
    tx_bit_i = 1'b1;
    @(negedge clk); cmp_stb_i = 1'b1; @(negedge clk); cmp_stb_i = 1'b0;
    wr(8'h02); rd(v); check("R5 value kept after clear", v, 8'h04);
    rx_i = 1'b0; idle(4);
    @(negedge clk); cmp_stb_i = 1'b1; @(negedge clk); cmp_stb_i = 1'b0;
    rd(v); check("R5 berr low seen", v, 8'h82);
    wr(8'h00); rd(v); check("R3 write 0 no effect", v, 8'h82);
    wr(8'hFF); rd(v); check("R3 clear all", v, 8'h00);
    rx_i = 1'b1; idle(4); berr_det_en_i = 1'b0;
  endtask

  task automatic t_break;
    logic [7:0] v;
    @(negedge clk); brk_rx_i = 1'b1; @(negedge clk); brk_rx_i = 1'b0;
    rd(v); check("R6 no break while disabled", v, 8'h00);
    brk_det_en_i = 1'b1;
    @(negedge clk); brk_rx_i = 1'b1; @(negedge clk); brk_rx_i = 1'b0;
    rd(v); check("R6 break flag", v, 8'h01);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    @(negedge clk);
    brk_rx_i = 1'b1; reg_wr_i = 1'b1; reg_wdata_i = 8'h01;
    @(negedge clk);
    brk_rx_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
    rd(v); check("R10 set wins over clear", v, 8'h01);
    wr(8'h01); rd(v); check("R10 quiet clear works", v, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    @(negedge clk); brk_rx_i = 1'b1; @(negedge clk); brk_rx_i = 1'b0;
    check("R7 irq masked", {7'd0, irq_o}, 8'h00);
    brk_ie_i = 1'b1; @(negedge clk);
    check("R7 irq break enabled", {7'd0, irq_o}, 8'h01);
    wr(8'h01); check("R7 irq drops on clear", {7'd0, irq_o}, 8'h00);
    edge_ie_i = 1'b1; rx_i = 1'b0; idle(4);
    check("R7 irq from edge", {7'd0, irq_o}, 8'h01);
    edge_ie_i = 1'b0; @(negedge clk);
    check("R7 irq edge masked", {7'd0, irq_o}, 8'h00);
    wr(8'h80); rx_i = 1'b1; idle(4); rd(v);
    check("R7 status clean", v, 8'h00);
    brk_ie_i = 1'b0;
  endtask

  task automatic t_altmap;
    logic [7:0] v;
    @(negedge clk); brk_rx_i = 1'b1; @(negedge clk); brk_rx_i = 1'b0;
    alt_map_i = 1'b0;
    rd(v); check("R8 read off map is 0", v, 8'h00);
    wr(8'hFF);
    alt_map_i = 1'b1;
    rd(v); check("R8 write off map ignored", v, 8'h01);
    @(negedge clk); check("R11 rdata returns to 0", reg_rdata_o, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3); rst = 1'b0; idle(2);
    t_reset();
    t_edge();
    t_berr();
    t_break();
    t_collision();
    t_irq();
    t_altmap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule